// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block merges the reset causes of a small microcontroller core into a single synchronous core reset. There are four causes. A power-good input from an analog detector, treated as a plain digital level, starts a cold reset. An active-high external pin counts only after it has stayed high for a minimum number of consecutive cycles. A prescaled watchdog overflows unless firmware services it. Firmware can also request a reset through a register write. Once every source has gone quiet, a release sequencer holds the core in reset for a fixed number of further cycles.

A small register port is used by firmware. The power-control register sits at address 0x87 and carries a sticky power-up flag in bit 4. Warm resets leave that flag alone, so firmware can tell a cold start from any other restart. A watchdog control register and a software-reset register are also on the port. The block records which warm source fired last. It also presents a boot vector that a configuration input selects while the core is in reset.

Top module: `rstctl_top`

## Requirements
- R1: The reset pin triggers a reset only after it has been sampled high on at least 24 consecutive clock edges. A pulse sampled high on 23 or fewer edges has no effect.
- R2: While power-good is low, the core reset is asserted and the whole block returns to its power-up state. A drop in power-good at any time repeats this.
- R3: The core reset deasserts on the 16th consecutive clock edge at which no source is active. Any active source restarts that count.
- R4: The power-up flag is set while power-good is low. It reads as bit 4 of register 0x87.
- R5: Pin, watchdog and software resets leave the power-up flag unchanged. A write to 0x87 with bit 4 at 0 clears it. A write with bit 4 at 1 does not change it.
- R6: The other bits of 0x87 are writable storage, and they read back as 0 after any reset.
- R7: The watchdog control register is at 0xC1. Bit 5 enables the watchdog and bits 2:0 select the prescale P = 2^value. When enabled, the 15-bit watchdog count advances once every 12·P cycles. Advancing from all-ones is an overflow, and an overflow triggers a reset.
- R8: Writing 0xC1 with bit 4 set clears both the watchdog count and the prescale divider. Bit 4 reads back as 0.
- R9: Only power-down clears the watchdog enable and prescale fields; warm resets keep them. While the core reset is asserted, the watchdog count and divider are held at zero.
- R10: Writing 0xE7 with bit 5 set requests a software reset. The core reset is asserted after that edge.
- R11: The reset cause output is one-hot: bit 0 means pin, bit 1 means watchdog, bit 2 means software. It is updated whenever a source fires, with pin taking priority over watchdog and watchdog over software. It reads 0 after power-up.
- R12: While the core reset is asserted, the boot vector follows the select input: 0x0000 for 0, 0xF000 for 1. While the core runs, the boot vector is frozen.
- R13: All register writes are ignored while the core reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| pwr_good_i | input | 1 | Supply-above-threshold level, low means power down |
| ext_rst_i | input | 1 | External reset pin, active high |
| boot_sel_i | input | 1 | Boot vector configuration select |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i, combinational |
| core_rst_o | output | 1 | Combined core reset, active high |
| boot_vec_o | output | 16 | Start vector after reset |
| rst_cause_o | output | 3 | One-hot last warm reset cause |
| por_flag_o | output | 1 | Sticky power-up flag |

## Verification
A pin or software source becomes visible on the core reset one cycle after the edge at which it is qualified or written. A watchdog overflow shows up after the edge at which the count leaves all-ones. Release comes 16 quiet edges after the last active one. Register writes and the recorded cause take effect at the write or trigger edge, and the read data is combinational from the address. The bench advances a behavioural model at every rising edge with the same input values the design sees, and compares every output at the following falling edge. Directed checks are placed at points where each expected value is stable by a margin of several cycles.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

    typedef enum logic [1:0] {
        SEQ_RUN     = 2'd0,
        SEQ_HOLD    = 2'd1,
        SEQ_STRETCH = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic sw;
        logic wdt;
        logic pin;
    } cause_t;

    localparam logic [7:0] ADDR_PWRCTL = 8'h87;
    localparam logic [7:0] ADDR_WDTCTL = 8'hC1;
    localparam logic [7:0] ADDR_SWRST  = 8'hE7;

    localparam int POF_BIT     = 4;
    localparam int SWRST_BIT   = 5;
    localparam int WDT_EN_BIT  = 5;
    localparam int WDT_CLR_BIT = 4;

endpackage

// File: rtl/rstctl_pin_filter.sv
module rstctl_pin_filter #(
    parameter int QUAL_LEN = 24
) (
    input  logic clk_i,
    input  logic pwr_good_i,
    input  logic pin_i,
    output logic qual_o
);
    localparam int CW = $clog2(QUAL_LEN + 1);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk_i) begin
        if (!pwr_good_i || !pin_i) begin
            run_cnt <= '0;
        end else if (run_cnt != CW'(QUAL_LEN)) begin
            run_cnt <= run_cnt + CW'(1);
        end
    end

    assign qual_o = (run_cnt == CW'(QUAL_LEN));
endmodule

// File: rtl/rstctl_wdt.sv
module rstctl_wdt #(
    parameter int CNT_W = 15,
    parameter int PS_W  = 3,
    parameter int BASE  = 12
) (
    input  logic            clk_i,
    input  logic            pwr_good_i,
    input  logic            hold_i,
    input  logic            clr_i,
    input  logic            en_i,
    input  logic [PS_W-1:0] ps_i,
    output logic            ovf_o
);
    localparam int MAX_DIV = BASE << ((1 << PS_W) - 1);
    localparam int DIV_W   = $clog2(MAX_DIV);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_last;
    logic [CNT_W-1:0] cnt_q;
    logic             tick;

    always_comb begin
        div_last = DIV_W'((BASE << ps_i) - 1);
        tick     = en_i && !hold_i && (div_q == div_last);
        ovf_o    = tick && (&cnt_q);
    end

    always_ff @(posedge clk_i) begin
        if (!pwr_good_i || hold_i || clr_i) begin
            div_q <= '0;
            cnt_q <= '0;
        end else if (en_i) begin
            if (tick) begin
                div_q <= '0;
                cnt_q <= cnt_q + CNT_W'(1);
            end else begin
                div_q <= div_q + DIV_W'(1);
            end
        end
    end
endmodule

// File: rtl/rstctl_seq.sv
module rstctl_seq
    import rstctl_pkg::*;
#(
    parameter int STRETCH_LEN = 16
) (
    input  logic   clk_i,
    input  logic   pwr_good_i,
    input  logic   pin_hit_i,
    input  logic   wdt_hit_i,
    input  logic   sw_hit_i,
    output logic   core_rst_o,
    output cause_t cause_o
);
    localparam int RW = $clog2(STRETCH_LEN + 1);

    seq_state_e    state_q, state_nx;
    logic [RW-1:0] rem_q, rem_nx;
    logic          src_any;

    assign src_any = pin_hit_i | wdt_hit_i | sw_hit_i;

    // state register
    always_ff @(posedge clk_i) begin
        if (!pwr_good_i) begin
            state_q <= SEQ_HOLD;
            rem_q   <= RW'(STRETCH_LEN);
        end else begin
            state_q <= state_nx;
            rem_q   <= rem_nx;
        end
    end

    always_comb begin
        state_nx = state_q;
        rem_nx   = rem_q;
        unique case (state_q)
            SEQ_HOLD: begin
                if (!src_any) begin
                    state_nx = SEQ_STRETCH;
                    rem_nx   = RW'(STRETCH_LEN - 1);
                end
            end
            SEQ_STRETCH: begin
                if (src_any) begin
                    state_nx = SEQ_HOLD;
                    rem_nx   = RW'(STRETCH_LEN);
                end else if (rem_q == RW'(1)) begin
                    state_nx = SEQ_RUN;
                    rem_nx   = '0;
                end else begin
                    rem_nx = rem_q - RW'(1);
                end
            end
            SEQ_RUN: begin
                if (src_any) begin
                    state_nx = SEQ_HOLD;
                    rem_nx   = RW'(STRETCH_LEN);
                end
            end
            default: begin
                state_nx = SEQ_HOLD;
                rem_nx   = RW'(STRETCH_LEN);
            end
        endcase
    end

    // outputs
    always_comb begin
        core_rst_o = (state_q != SEQ_RUN);
    end

    always_ff @(posedge clk_i) begin
        if (!pwr_good_i) begin
            cause_o <= '0;
        end else if (pin_hit_i) begin
            cause_o <= '{sw: 1'b0, wdt: 1'b0, pin: 1'b1};
        end else if (wdt_hit_i) begin
            cause_o <= '{sw: 1'b0, wdt: 1'b1, pin: 1'b0};
        end else if (sw_hit_i) begin
            cause_o <= '{sw: 1'b1, wdt: 1'b0, pin: 1'b0};
        end
    end
endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
    import rstctl_pkg::*;
#(
    parameter int              QUAL_LEN    = 24,
    parameter int              STRETCH_LEN = 16,
    parameter int              WDT_W       = 15,
    parameter int              PS_W        = 3,
    parameter int              WDT_BASE    = 12,
    parameter int              VEC_W       = 16,
    parameter logic [VEC_W-1:0] ISP_VEC    = 16'hF000
) (
    input  logic             clk_i,
    input  logic             pwr_good_i,
    input  logic             ext_rst_i,
    input  logic             boot_sel_i,
    input  logic             reg_wr_i,
    input  logic [7:0]       reg_addr_i,
    input  logic [7:0]       reg_wdata_i,
    output logic [7:0]       reg_rdata_o,
    output logic             core_rst_o,
    output logic [VEC_W-1:0] boot_vec_o,
    output logic [2:0]       rst_cause_o,
    output logic             por_flag_o
);
    logic            pin_hit, wdt_hit, sw_hit;
    logic            wr_ok, wdt_clr;
    logic            wdt_en;
    logic [PS_W-1:0] wdt_ps;
    logic [7:0]      pctl_bits;
    logic [7:0]      wctl_view;
    cause_t          cause;

    assign wr_ok   = reg_wr_i && !core_rst_o;
    assign sw_hit  = wr_ok && (reg_addr_i == ADDR_SWRST)  && reg_wdata_i[SWRST_BIT];
    assign wdt_clr = wr_ok && (reg_addr_i == ADDR_WDTCTL) && reg_wdata_i[WDT_CLR_BIT];

    rstctl_pin_filter #(.QUAL_LEN(QUAL_LEN)) u_pin (
        .clk_i      (clk_i),
        .pwr_good_i (pwr_good_i),
        .pin_i      (ext_rst_i),
        .qual_o     (pin_hit)
    );

    rstctl_wdt #(.CNT_W(WDT_W), .PS_W(PS_W), .BASE(WDT_BASE)) u_wdt (
        .clk_i      (clk_i),
        .pwr_good_i (pwr_good_i),
        .hold_i     (core_rst_o),
        .clr_i      (wdt_clr),
        .en_i       (wdt_en),
        .ps_i       (wdt_ps),
        .ovf_o      (wdt_hit)
    );

    rstctl_seq #(.STRETCH_LEN(STRETCH_LEN)) u_seq (
        .clk_i      (clk_i),
        .pwr_good_i (pwr_good_i),
        .pin_hit_i  (pin_hit),
        .wdt_hit_i  (wdt_hit),
        .sw_hit_i   (sw_hit),
        .core_rst_o (core_rst_o),
        .cause_o    (cause)
    );

    always_ff @(posedge clk_i) begin
        if (!pwr_good_i) begin
            por_flag_o <= 1'b1;
            pctl_bits  <= '0;
            wdt_en     <= 1'b0;
            wdt_ps     <= '0;
        end else begin
            if (core_rst_o) begin
                pctl_bits <= '0;
            end else if (wr_ok && reg_addr_i == ADDR_PWRCTL) begin
                pctl_bits <= reg_wdata_i & ~(8'h01 << POF_BIT);
                if (!reg_wdata_i[POF_BIT]) begin
                    por_flag_o <= 1'b0;
                end
            end
            if (wr_ok && reg_addr_i == ADDR_WDTCTL) begin
                wdt_en <= reg_wdata_i[WDT_EN_BIT];
                wdt_ps <= reg_wdata_i[PS_W-1:0];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!pwr_good_i || core_rst_o) begin
            boot_vec_o <= boot_sel_i ? ISP_VEC : '0;
        end
    end

    always_comb begin
        wctl_view             = '0;
        wctl_view[WDT_EN_BIT] = wdt_en;
        wctl_view[PS_W-1:0]   = wdt_ps;
        unique case (reg_addr_i)
            ADDR_PWRCTL: reg_rdata_o = pctl_bits | (8'(por_flag_o) << POF_BIT);
            ADDR_WDTCTL: reg_rdata_o = wctl_view;
            default:     reg_rdata_o = '0;
        endcase
    end

    assign rst_cause_o = cause;
endmodule

// File: rtl/rstctl_chk.sv
module rstctl_chk #(
    parameter int QUAL_LEN    = 24,
    parameter int STRETCH_LEN = 16,
    parameter int VEC_W       = 16
) (
    input logic             clk_i,
    input logic             pwr_good_i,
    input logic             ext_rst_i,
    input logic             reg_wr_i,
    input logic [7:0]       reg_addr_i,
    input logic [7:0]       reg_wdata_i,
    input logic             core_rst_o,
    input logic [VEC_W-1:0] boot_vec_o,
    input logic [2:0]       rst_cause_o,
    input logic             por_flag_o,
    input logic             pin_hit,
    input logic             wdt_hit,
    input logic             sw_hit
);
    int hi_run;
    int quiet;

    always_ff @(posedge clk_i) begin
        if (!pwr_good_i || !ext_rst_i) hi_run <= 0;
        else if (hi_run < QUAL_LEN)    hi_run <= hi_run + 1;
    end

    always_ff @(posedge clk_i) begin
        if (!pwr_good_i || pin_hit || wdt_hit || sw_hit) quiet <= 0;
        else if (quiet < STRETCH_LEN)                    quiet <= quiet + 1;
    end

    assert_pin_qualified_R1: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        pin_hit |-> (hi_run == QUAL_LEN));

    assert_release_late_R3: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        !core_rst_o |-> (quiet == STRETCH_LEN));

    assert_release_due_R3: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        (quiet == STRETCH_LEN) |-> !core_rst_o);

    assert_pof_sticky_R5: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        (por_flag_o && !(reg_wr_i && reg_addr_i == 8'h87 && !reg_wdata_i[4])) |=> por_flag_o);

    assert_wdt_resets_R7: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        wdt_hit |=> core_rst_o);

    assert_sw_resets_R10: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        sw_hit |=> core_rst_o);

    assert_cause_onehot_R11: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        $onehot0(rst_cause_o));

    assert_boot_frozen_R12: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        (!core_rst_o && $past(!core_rst_o)) |-> $stable(boot_vec_o));
endmodule

bind rstctl_top rstctl_chk #(
    .QUAL_LEN    (QUAL_LEN),
    .STRETCH_LEN (STRETCH_LEN),
    .VEC_W       (VEC_W)
) chk_i (
    .clk_i       (clk_i),
    .pwr_good_i  (pwr_good_i),
    .ext_rst_i   (ext_rst_i),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .core_rst_o  (core_rst_o),
    .boot_vec_o  (boot_vec_o),
    .rst_cause_o (rst_cause_o),
    .por_flag_o  (por_flag_o),
    .pin_hit     (pin_hit),
    .wdt_hit     (wdt_hit),
    .sw_hit      (sw_hit)
);

// File: tb/rstctl_top_tb_top.sv
module rstctl_top_tb_top;
    localparam int          WW   = 6;
    localparam logic [15:0] ISPV = 16'hF000;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        pg = 1'b0, pin = 1'b0, bsel = 1'b0, wr = 1'b0;
    logic [7:0]  addr = 8'h00, wd = 8'h00;
    logic [7:0]  rdata;
    logic        core_rst, pof;
    logic [15:0] boot;
    logic [2:0]  cause;

    rstctl_top #(.WDT_W(WW)) dut_i (
        .clk_i(clk), .pwr_good_i(pg), .ext_rst_i(pin), .boot_sel_i(bsel),
        .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wd), .reg_rdata_o(rdata),
        .core_rst_o(core_rst), .boot_vec_o(boot), .rst_cause_o(cause), .por_flag_o(pof)
    );

    int checks = 0, errors = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model, advanced at each rising edge
    int         m_pin = 0, m_rem = 16, m_div = 0, m_wcnt = 0, m_ps = 0;
    bit         m_en = 1'b0, m_pof = 1'b1;
    logic [7:0] m_pctl = 8'h00;
    logic [2:0] m_cause = 3'b000;
    logic [15:0] m_boot = 16'h0000;

    always @(posedge clk) begin : model
        int last;
        bit c, pq, tk, ov, wok, swr, clr;
        if (!pg) begin
            m_pin = 0; m_rem = 16; m_div = 0; m_wcnt = 0; m_ps = 0;
            m_en = 1'b0; m_pof = 1'b1; m_pctl = 8'h00; m_cause = 3'b000;
            m_boot = bsel ? ISPV : 16'h0000;
        end else begin
            c    = (m_rem != 0);
            pq   = (m_pin == 24);
            last = 12 * (1 << m_ps) - 1;
            tk   = m_en && !c && (m_div == last);
            ov   = tk && (m_wcnt == (1 << WW) - 1);
            wok  = wr && !c;
            swr  = wok && addr == 8'hE7 && wd[5];
            clr  = wok && addr == 8'hC1 && wd[4];
            if (c) m_boot = bsel ? ISPV : 16'h0000;
            if (pq)       m_cause = 3'b001;
            else if (ov)  m_cause = 3'b010;
            else if (swr) m_cause = 3'b100;
            m_rem = (pq || ov || swr) ? 16 : (m_rem > 0 ? m_rem - 1 : 0);
            m_pin = pin ? (m_pin < 24 ? m_pin + 1 : 24) : 0;
            if (c || clr) begin
                m_div = 0; m_wcnt = 0;
            end else if (m_en) begin
                if (tk) begin m_div = 0; m_wcnt = (m_wcnt + 1) % (1 << WW); end
                else m_div = m_div + 1;
            end
            if (wok && addr == 8'hC1) begin m_en = wd[5]; m_ps = int'(wd[2:0]); end
            if (c) m_pctl = 8'h00;
            else if (wok && addr == 8'h87) begin
                m_pctl = wd & 8'hEF;
                if (!wd[4]) m_pof = 1'b0;
            end
        end
    end

    function automatic logic [7:0] m_rd(input logic [7:0] a);
        if (a == 8'h87) return m_pctl | (m_pof ? 8'h10 : 8'h00);
        if (a == 8'hC1) return {2'b00, m_en, 2'b00, 3'(m_ps)};
        return 8'h00;
    endfunction

    always @(negedge clk) begin
        if (!done) begin
            chk(core_rst === (m_rem != 0), "R1 R2 R3 R7 R10 core reset", 32'(core_rst), 32'(m_rem != 0));
            chk(cause === m_cause, "R11 cause", 32'(cause), 32'(m_cause));
            chk(pof === m_pof, "R4 R5 power flag", 32'(pof), 32'(m_pof));
            chk(boot === m_boot, "R12 boot vector", 32'(boot), 32'(m_boot));
            chk(rdata === m_rd(addr), "R6 R8 R9 R13 read data", 32'(rdata), 32'(m_rd(addr)));
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wreg(input logic [7:0] a, input logic [7:0] d);
        wr = 1'b1; addr = a; wd = d;
        step(1);
        wr = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        step(4);
        @(negedge clk);
        chk(core_rst === 1'b1, "R2 reset while power low", 32'(core_rst), 1);
        chk(pof === 1'b1, "R4 flag set at power up", 32'(pof), 1);
        pg = 1'b1;
        step(20);
        @(negedge clk);
        chk(core_rst === 1'b0, "R3 released after stretch", 32'(core_rst), 0);
        addr = 8'h87;
        @(negedge clk);
        chk(rdata === 8'h10, "R4 flag read at bit 4", 32'(rdata), 32'h10);
        wreg(8'h87, 8'h1F); addr = 8'h87;
        @(negedge clk);
        chk(rdata === 8'h1F, "R6 general bits writable", 32'(rdata), 32'h1F);

        pin = 1'b1; step(23); pin = 1'b0; step(3);
        @(negedge clk);
        chk(core_rst === 1'b0, "R1 short pulse ignored", 32'(core_rst), 0);
        pin = 1'b1; step(30); pin = 1'b0; step(5);
        @(negedge clk);
        chk(core_rst === 1'b1, "R1 long pulse resets", 32'(core_rst), 1);
        chk(cause === 3'b001, "R11 pin cause", 32'(cause), 1);
        step(20); addr = 8'h87;
        @(negedge clk);
        chk(rdata === 8'h10, "R5 R6 flag kept, other bits cleared", 32'(rdata), 32'h10);
        wreg(8'h87, 8'h10);
        @(negedge clk);
        chk(pof === 1'b1, "R5 writing one keeps flag", 32'(pof), 1);
        wreg(8'h87, 8'h00);
        @(negedge clk);
        chk(pof === 1'b0, "R5 writing zero clears flag", 32'(pof), 0);

        wreg(8'hE7, 8'h20);
        @(negedge clk);
        chk(core_rst === 1'b1, "R10 software reset", 32'(core_rst), 1);
        step(20);
        @(negedge clk);
        chk(cause === 3'b100, "R11 software cause", 32'(cause), 4);
        chk(pof === 1'b0, "R5 flag unchanged by software reset", 32'(pof), 0);

        wreg(8'hC1, 8'h20);
        for (int i = 0; i < 4; i++) begin
            step(500);
            wreg(8'hC1, 8'h30);
        end
        @(negedge clk);
        chk(core_rst === 1'b0, "R8 serviced watchdog stays quiet", 32'(core_rst), 0);
        step(770);
        @(negedge clk);
        chk(core_rst === 1'b1, "R7 watchdog overflow resets", 32'(core_rst), 1);
        chk(cause === 3'b010, "R11 watchdog cause", 32'(cause), 2);
        step(20); addr = 8'hC1;
        @(negedge clk);
        chk(rdata === 8'h20, "R9 enable kept through warm reset", 32'(rdata), 32'h20);
        wreg(8'hC1, 8'h31);
        step(1530);
        @(negedge clk);
        chk(core_rst === 1'b0, "R7 prescale 2 not yet due", 32'(core_rst), 0);
        step(10);
        @(negedge clk);
        chk(core_rst === 1'b1, "R7 prescale 2 overflow", 32'(core_rst), 1);
        step(20);
        wreg(8'hC1, 8'h00);

        pin = 1'b1; step(26);
        wreg(8'hC1, 8'h25);
        pin = 1'b0; step(25); addr = 8'hC1;
        @(negedge clk);
        chk(rdata === 8'h00, "R13 write during reset ignored", 32'(rdata), 0);

        bsel = 1'b1; step(3);
        @(negedge clk);
        chk(boot === 16'h0000, "R12 frozen while running", 32'(boot), 0);
        wreg(8'hE7, 8'h20); step(2);
        @(negedge clk);
        chk(boot === ISPV, "R12 follows select in reset", 32'(boot), 32'(ISPV));
        step(20); bsel = 1'b0; step(2);
        @(negedge clk);
        chk(boot === ISPV, "R12 held after release", 32'(boot), 32'(ISPV));

        pin = 1'b1; step(24);
        wreg(8'hE7, 8'h20);
        pin = 1'b0; step(3);
        @(negedge clk);
        chk(cause === 3'b001, "R11 pin wins over software", 32'(cause), 1);
        step(20);

        wreg(8'hC1, 8'h23);
        pg = 1'b0; step(3);
        @(negedge clk);
        chk(pof === 1'b1, "R4 flag set on power drop", 32'(pof), 1);
        chk(cause === 3'b000, "R11 cause cleared at power up", 32'(cause), 0);
        chk(core_rst === 1'b1, "R2 power drop resets", 32'(core_rst), 1);
        pg = 1'b1; step(20); addr = 8'hC1;
        @(negedge clk);
        chk(rdata === 8'h00, "R9 power drop clears watchdog control", 32'(rdata), 0);
        finish_run();
    end
endmodule